// File: doc/BRIEF.md
# Programmable BCD Down Counter

This block is one decade of a decimal down-counter. It steps through 9, 8, … 0 and then wraps back to 9. A four-bit preset word can be loaded into it at any time. Two slow external inputs, a count clock and an inhibit, decide when a count happens. A count is made either when the count clock rises while the inhibit is low, or when the inhibit falls while the count clock is high. The block treats these two inputs as one combined trigger: a count occurs when the pair enters the "clock high, inhibit low" condition. Two level inputs act at once on the visible count, without waiting for any clock: a clear, which forces zero and overrides everything else, and a load enable, which shows the preset word.

The zero flag is high only when the visible count is 0000 and the feedback input is high. Stages of a multi-decade divider can use this flag to chain to each other. A single stage becomes a divide-by-N counter when its zero flag is returned, through one register, to its own load enable.

Internally the count clock and the inhibit are oversampled on the system clock `clk`, each through a synchronizer of `SYNC_STAGES` flops. A four-state trigger FSM holds the last sampled {count clock, inhibit} pair:
- TRIG_LOW_OPEN: clock low, inhibit low.
- TRIG_LOW_SHUT: clock low, inhibit high.
- TRIG_HIGH_OPEN: clock high, inhibit low.
- TRIG_HIGH_SHUT: clock high, inhibit high.

Every cycle the FSM moves to the state that matches the newly sampled pair. The transitions into TRIG_HIGH_OPEN from TRIG_LOW_OPEN (clock rise), from TRIG_HIGH_SHUT (inhibit fall) and from TRIG_LOW_SHUT (both change together) each raise a one-cycle step. Every other transition is inactive: clock fall, inhibit rise, clock rise under inhibit, and staying in the same state.

Top module: `bcd_down_counter`

## Requirements
- R1: While `clear` is high, `count` reads 0000 at once, with no `clk` edge needed, whatever `load_en` shows. The stored value is also zeroed.
- R2: While `clear` is low and `load_en` is high, `count` equals `preset` at once, with no `clk` edge needed. After `load_en` falls, the loaded value is held.
- R3: A rising `cnt_clk` while `cnt_inh` is low decrements the count by one. The change appears on `count` after the third rising `clk` edge following the input change (with `SYNC_STAGES` = 2), and not before it.
- R4: A falling `cnt_inh` while `cnt_clk` is high decrements the count by one, with the same latency as in R3.
- R5: A falling `cnt_clk`, a rising `cnt_inh`, or a rising `cnt_clk` while `cnt_inh` is high leaves the count unchanged.
- R6: A decrement from 0000 gives 1001. From any value v in 1..9, a decrement gives v−1.
- R7: `zero` is high exactly when `count` is 0000 and `feedback` is high. It is combinational from these two signals.
- R8: Trigger events that occur while `clear` or `load_en` is high do not change the count.
- R9: While `rst_n` is low, the stored count is 0000 and the trigger FSM is in TRIG_LOW_OPEN.
- R10: If `zero` is registered once on `clk` and drives `load_en`, with `feedback` high and a preset N in 1..9, then `zero` rises once every N count events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the trigger inputs |
| rst_n | input | 1 | Active-low asynchronous reset of internal registers |
| cnt_clk | input | 1 | Count clock; its rising edge counts when inhibit is low |
| cnt_inh | input | 1 | Count inhibit; its falling edge counts when count clock is high |
| clear | input | 1 | Immediate clear to 0000, highest priority |
| load_en | input | 1 | Immediate load of `preset` while high |
| feedback | input | 1 | Qualifies the zero flag |
| preset | input | 4 | Preset BCD digit |
| count | output | 4 | Visible BCD count |
| zero | output | 1 | High when count is 0000 and feedback is high |

## Verification
The hardest situation to reach from the ports is a divide-by-N loop, in which the block's own zero flag reloads it. The reload has to land between two trigger events, and the gap between zero pulses must measure exactly N. The bench closes this loop through one register and runs it for every N from 1 to 9. It counts the trigger pulses between consecutive rises of `zero`. A second hard case is the inhibit-edge trigger, which only occurs after the count clock has been raised while inhibit is high. The bench builds that sequence explicitly, and it checks both inactive edges along the way.

// File: rtl/bcd_dn_pkg.sv
package bcd_dn_pkg;

    localparam int BCD_W = 4;
    typedef logic [BCD_W-1:0] bcd_t;

    localparam bcd_t BCD_TOP  = 4'd9;
    localparam bcd_t BCD_ZERO = 4'd0;

    // Encoding is {count clock, inhibit} as last sampled.
    typedef enum logic [1:0] {
        TRIG_LOW_OPEN  = 2'b00,
        TRIG_LOW_SHUT  = 2'b01,
        TRIG_HIGH_OPEN = 2'b10,
        TRIG_HIGH_SHUT = 2'b11
    } trig_state_e;

    function automatic bcd_t bcd_dec(input bcd_t v);
        bcd_t r;
        if (v == BCD_ZERO) r = BCD_TOP;
        else               r = v - 4'd1;
        return r;
    endfunction

endpackage

// File: rtl/bcd_edge_sync.sv
module bcd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[LAST-1:0], d};
            end
        end
    endgenerate

    assign q = sr[LAST];
endmodule

// File: rtl/bcd_trig_fsm.sv
module bcd_trig_fsm
    import bcd_dn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cclk_s,
    input  logic inh_s,
    output logic step
);
    trig_state_e state_q, state_d;
    logic        to_open;

    // Next state: the freshly sampled pair.
    always_comb begin
        unique case ({cclk_s, inh_s})
            2'b00:   state_d = TRIG_LOW_OPEN;
            2'b01:   state_d = TRIG_LOW_SHUT;
            2'b10:   state_d = TRIG_HIGH_OPEN;
            default: state_d = TRIG_HIGH_SHUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRIG_LOW_OPEN;
        else        state_q <= state_d;
    end

    // Output: a step on each entry into TRIG_HIGH_OPEN.
    always_comb begin
        to_open = (state_d == TRIG_HIGH_OPEN);
        unique case (state_q)
            TRIG_LOW_OPEN:  step = to_open;   // clock rise
            TRIG_LOW_SHUT:  step = to_open;   // clock rise with inhibit fall
            TRIG_HIGH_SHUT: step = to_open;   // inhibit fall
            TRIG_HIGH_OPEN: step = 1'b0;      // already counted
            default:        step = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
    import bcd_dn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic load_en,
    input  bcd_t preset,
    input  logic step,
    input  logic feedback,
    output bcd_t cnt_q,
    output bcd_t count,
    output logic zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= BCD_ZERO;
        else if (clear)   cnt_q <= BCD_ZERO;
        else if (load_en) cnt_q <= preset;
        else if (step)    cnt_q <= bcd_dec(cnt_q);
    end

    // Level controls act on the visible value without a clock edge.
    always_comb begin
        if (clear)        count = BCD_ZERO;
        else if (load_en) count = preset;
        else              count = cnt_q;
    end

    assign zero = feedback && (count == BCD_ZERO);
endmodule

// File: rtl/bcd_down_counter.sv
module bcd_down_counter
    import bcd_dn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clk,
    input  logic             cnt_inh,
    input  logic             clear,
    input  logic             load_en,
    input  logic             feedback,
    input  logic [BCD_W-1:0] preset,
    output logic [BCD_W-1:0] count,
    output logic             zero
);
    logic cclk_s, inh_s, step;
    bcd_t cnt_q;

    bcd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d(cnt_clk), .q(cclk_s));

    bcd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_inh (
        .clk(clk), .rst_n(rst_n), .d(cnt_inh), .q(inh_s));

    bcd_trig_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cclk_s(cclk_s), .inh_s(inh_s), .step(step));

    bcd_digit u_digit (
        .clk(clk), .rst_n(rst_n), .clear(clear), .load_en(load_en),
        .preset(preset), .step(step), .feedback(feedback),
        .cnt_q(cnt_q), .count(count), .zero(zero));
endmodule

// File: rtl/bcd_down_counter_chk.sv
module bcd_down_counter_chk
    import bcd_dn_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic clear,
    input logic load_en,
    input logic feedback,
    input bcd_t count,
    input logic zero,
    input bcd_t cnt_q,
    input logic step
);
    p_clear_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> count == BCD_ZERO);

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !load_en && cnt_q != BCD_ZERO)
            |=> cnt_q == 4'($past(cnt_q) - 4'd1));

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear && !load_en) |=> $stable(cnt_q));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !load_en && cnt_q == BCD_ZERO) |=> cnt_q == BCD_TOP);

    p_zero_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (feedback && count == BCD_ZERO) |-> zero);

    p_zero_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        zero |-> (feedback && count == BCD_ZERO));
endmodule

bind bcd_down_counter bcd_down_counter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load_en(load_en),
    .feedback(feedback), .count(count), .zero(zero),
    .cnt_q(cnt_q), .step(step));

// File: tb/bcd_down_counter_test.sv
module bcd_down_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_clk = 1'b0, cnt_inh = 1'b0, clear = 1'b0;
    logic       load_man = 1'b0, loop_mode = 1'b0, loop_q = 1'b0;
    logic       feedback = 1'b1;
    logic [3:0] preset = 4'd0;
    logic [3:0] count;
    logic       zero, load_en;

    int checks = 0, errors = 0;
    int evt_idx = 0, rises = 0, rise_last = 0, rise_prev = 0;
    logic zero_prev = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    assign load_en = loop_mode ? loop_q : load_man;
    always @(posedge clk) loop_q <= zero;

    bcd_down_counter uut (
        .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .cnt_inh(cnt_inh),
        .clear(clear), .load_en(load_en), .feedback(feedback),
        .preset(preset), .count(count), .zero(zero));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            if (zero && !zero_prev) begin
                rise_prev = rise_last;
                rise_last = evt_idx;
                rises++;
            end
            zero_prev = zero;
        end
    endtask

    task automatic pulse();
        evt_idx++;
        cnt_clk = 1'b1; tick(4);
        cnt_clk = 1'b0; tick(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1600000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        chk("R9 reset count", count, 0);
        chk("R7 zero at reset", zero, 1);
        rst_n = 1'b1; tick(2);

        // R2 immediate load and hold
        preset = 4'd7; load_man = 1'b1; #1;
        chk("R2 immediate load", count, 7);
        tick(1); load_man = 1'b0; preset = 4'd2; tick(2);
        chk("R2 hold after load", count, 7);

        // R3 exact latency
        cnt_clk = 1'b1; tick(2);
        chk("R3 before third edge", count, 7);
        tick(1);
        chk("R3 after third edge", count, 6);
        cnt_clk = 1'b0; tick(4);
        chk("R5 clock fall inactive", count, 6);

        // R4 / R5 inhibit edges
        cnt_inh = 1'b1; tick(4);
        cnt_clk = 1'b1; tick(4);
        chk("R5 clock rise under inhibit", count, 6);
        cnt_inh = 1'b0; tick(2);
        chk("R4 before third edge", count, 6);
        tick(1);
        chk("R4 inhibit fall counts", count, 5);
        cnt_inh = 1'b1; tick(4);
        chk("R5 inhibit rise inactive", count, 5);
        cnt_inh = 1'b0; tick(4);
        chk("R4 second inhibit fall", count, 4);
        cnt_clk = 1'b0; tick(4);
        chk("R5 clock fall hold", count, 4);

        // R6 / R7 sweep over every start digit
        for (int p = 0; p < 10; p++) begin
            preset = 4'(p); load_man = 1'b1; tick(2); load_man = 1'b0; tick(1);
            for (int k = 1; k <= 12; k++) begin
                int exp;
                feedback = k[0];
                pulse();
                exp = ((p - k) % 10 + 10) % 10;
                chk("R6 sweep count", count, exp);
                chk("R7 sweep zero", zero, (exp == 0 && feedback) ? 1 : 0);
            end
        end

        // R1 / R8 priority and blocking
        preset = 4'd5; load_man = 1'b1; tick(1);
        clear = 1'b1; feedback = 1'b1; #1;
        chk("R1 clear overrides load", count, 0);
        chk("R7 zero under clear", zero, 1);
        feedback = 1'b0; #1;
        chk("R7 zero needs feedback", zero, 0);
        pulse();
        chk("R8 no count under clear", count, 0);
        clear = 1'b0; #1;
        chk("R2 load after clear", count, 5);
        pulse();
        chk("R8 no count under load", count, 5);
        load_man = 1'b0; tick(2);
        chk("R1 R2 stored load", count, 5);
        pulse();
        chk("R3 count resumes", count, 4);

        // R10 divide-by-N loop
        feedback = 1'b1;
        for (int n = 1; n <= 9; n++) begin
            loop_mode = 1'b0; preset = 4'(n);
            load_man = 1'b1; tick(2); load_man = 1'b0; tick(2);
            rises = 0; loop_mode = 1'b1; tick(1);
            for (int j = 0; j < 2 * n + 1; j++) pulse();
            chk("R10 zero pulses seen", (rises >= 2) ? 1 : 0, 1);
            chk("R10 divide period", rise_last - rise_prev, n);
        end
        loop_mode = 1'b0;

        finish_run();
    end
endmodule